// File: doc/BRIEF.md
# Dual-Mode Floppy Controller Bus Glue

This block connects an 8-bit host I/O bus to one floppy disk controller core that can serve either as a high-density or as a double-density interface. It recognises two banks of three byte-wide ports: status, data and control. A small mode register decides which bank is live. Accesses to the other bank are dropped. Status and data accesses on the live bank go straight through to the controller core. The block synthesises the control-port and mode-port read values itself.

The control register produces three things: a one-cycle controller reset pulse, the drive-ready level, and the arming of a motor-settle one-shot timer. The timer is a three-state machine. `TM_IDLE` moves to `TM_RUN` when a control write has bit 0 set. `TM_RUN` counts down and moves to `TM_FIRE` when the count is exhausted. A fresh arm in `TM_RUN` reloads the count and stays in `TM_RUN`. `TM_FIRE` lasts one cycle and then returns to `TM_IDLE`, or goes back to `TM_RUN` if it is re-armed. While in `TM_FIRE`, the block pulses interrupt line 2, but only if the stored control bit 2 is set. Mode bit 0 also steers the controller's interrupt and DMA request to one of two destinations.

Top module: `fdc_bus_glue`

## Requirements
- R1: Status/data ports (0x90/0x92 for the high-density bank, 0xC8/0xCA for the double-density bank) and control ports (0x94, 0xCC) act only when address bit 4 equals mode bit 0. A live status/data write raises `fdc_wr` with `fdc_reg` = 1 for the data port. A write to the dead bank has no effect.
- R2: Reads of a dead-bank port, or of any address that is not decoded (full 16-bit compare), return 0xFF. A live status/data read returns `fdc_rdata`.
- R3: A live control write pulses `fdc_reset` for exactly one cycle, in the cycle after the write, only when data bit 7 is 1 and the stored bit 7 is 0. The written byte becomes the stored control value.
- R4: A live control write copies data bit 6 to `fdc_ready`. A write to 0xCC with data bit 5 clear leaves `fdc_ready` unchanged.
- R5: A live control write with bit 0 set (re)starts the timer and discards any pending expiry. Exactly TICKS = CLK_FREQ_HZ/1000*TIMEOUT_MS clock edges after the arming edge, `irq_line2` pulses for one cycle.
- R6: If stored control bit 2 is clear when the timer expires, no pulse is produced.
- R7: A write to the mode port 0xBE that takes mode bit 1 from 0 to 1 sets `drive_hd[1:0]` to 2'b11. A write that takes it from 1 to 0 clears them. `drive_hd[NUM_DRIVES-1:2]` stay 1.
- R8: Reading 0xBE returns 0xF8 OR mode bits [1:0].
- R9: With mode bit 0 = 1, reading 0x94 returns 0x44. With mode bit 0 = 0, reading 0xCC returns 0x64 with bit 4 = `disk_in`.
- R10: With mode bit 0 = 1, `fdc_irq` appears on `irq_line3` and `fdc_drq` on `dma_ch2`. With mode bit 0 = 0, they appear on `irq_line2` and `dma_ch3`. The destination that is not selected stays low.
- R11: After reset the stored control value is 0x80 and the mode is 2'b11. `drive_hd` is all ones, `fdc_ready` and `fdc_reset` are low, and no timer is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Host I/O address |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data returned to the host |
| fdc_wr | output | 1 | Write strobe to controller core |
| fdc_rd | output | 1 | Read strobe to controller core |
| fdc_reg | output | 1 | Controller register select, 1 = data, 0 = status |
| fdc_wdata | output | 8 | Write data to controller core |
| fdc_rdata | input | 8 | Read data from controller core |
| fdc_reset | output | 1 | One-cycle controller reset pulse |
| fdc_ready | output | 1 | Drive-ready level to controller |
| drive_hd | output | NUM_DRIVES | Per-drive type, 1 = high density |
| disk_in | input | 1 | Media present indication |
| fdc_irq | input | 1 | Controller interrupt request |
| fdc_drq | input | 1 | Controller DMA request |
| irq_line2 | output | 1 | Interrupt line 2 (double-density IRQ and timer) |
| irq_line3 | output | 1 | Interrupt line 3 (high-density IRQ) |
| dma_ch2 | output | 1 | DMA request channel 2 |
| dma_ch3 | output | 1 | DMA request channel 3 |

## Verification
The assertions take for granted that `bus_wr` and `bus_rd` are never high together and that each write strobe lasts exactly one cycle. They also assume that `drive_hd` and `fdc_ready` change only as the result of a host write. The stimulus issues every access through a task that raises one strobe for a single cycle. It changes the mode only through port 0xBE, and it holds `fdc_irq` low while the timer pulse on line 2 is being timed, so that the routed interrupt cannot mask it.

// File: rtl/fdcg_pkg.sv
package fdcg_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] HD_STAT = 16'h0090;
    localparam logic [ADDR_W-1:0] HD_DATA = 16'h0092;
    localparam logic [ADDR_W-1:0] HD_CTRL = 16'h0094;
    localparam logic [ADDR_W-1:0] DD_STAT = 16'h00C8;
    localparam logic [ADDR_W-1:0] DD_DATA = 16'h00CA;
    localparam logic [ADDR_W-1:0] DD_CTRL = 16'h00CC;
    localparam logic [ADDR_W-1:0] MODE_PORT = 16'h00BE;

    localparam logic [DATA_W-1:0] HD_CTRL_RD = 8'h44;
    localparam logic [DATA_W-1:0] DD_CTRL_RD = 8'h64;
    localparam logic [DATA_W-1:0] MODE_RD_HI = 8'hF8;
    localparam logic [DATA_W-1:0] OPEN_BUS  = 8'hFF;

    typedef enum logic [2:0] {
        PK_NONE,
        PK_STAT,
        PK_DATA,
        PK_CTRL,
        PK_MODE
    } port_kind_e;

    typedef enum logic [1:0] {
        TM_IDLE,
        TM_RUN,
        TM_FIRE
    } tmr_state_e;
endpackage

// File: rtl/fdcg_decode.sv
module fdcg_decode
    import fdcg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              mode_bank,
    output port_kind_e        kind,
    output logic              live,
    output logic              dd_ctrl
);
    always_comb begin
        case (addr)
            HD_STAT, DD_STAT: kind = PK_STAT;
            HD_DATA, DD_DATA: kind = PK_DATA;
            HD_CTRL, DD_CTRL: kind = PK_CTRL;
            MODE_PORT:        kind = PK_MODE;
            default:          kind = PK_NONE;
        endcase
    end

    // bank ports respond only when their address bit 4 matches the bank select
    assign live    = (kind inside {PK_STAT, PK_DATA, PK_CTRL}) && (addr[4] == mode_bank);
    assign dd_ctrl = (addr == DD_CTRL);
endmodule

// File: rtl/fdcg_regs.sv
module fdcg_regs
    import fdcg_pkg::*;
#(
    parameter int NUM_DRIVES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              mode_we,
    input  logic              dd_port,
    input  logic [DATA_W-1:0] wdata,
    output logic              irq_en,
    output logic [1:0]        mode_q,
    output logic              fdc_reset,
    output logic              ready,
    output logic [NUM_DRIVES-1:0] drive_hd,
    output logic              arm
);
    localparam int SWITCHED = 2;

    logic ctrl_b7;
    logic ctrl_b2;
    logic unused_wbits;

    assign unused_wbits = ^{wdata[4:3]};
    assign arm    = ctrl_we && wdata[0];
    assign irq_en = ctrl_b2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_b7   <= 1'b1;
            ctrl_b2   <= 1'b0;
            mode_q    <= 2'b11;
            fdc_reset <= 1'b0;
            ready     <= 1'b0;
            drive_hd  <= '1;
        end else begin
            fdc_reset <= ctrl_we && !ctrl_b7 && wdata[7];
            if (ctrl_we) begin
                ctrl_b7 <= wdata[7];
                ctrl_b2 <= wdata[2];
                if (!(dd_port && !wdata[5])) begin
                    ready <= wdata[6];
                end
            end
            if (mode_we) begin
                mode_q <= wdata[1:0];
                if (!mode_q[1] && wdata[1]) begin
                    drive_hd[SWITCHED-1:0] <= '1;
                end else if (mode_q[1] && !wdata[1]) begin
                    drive_hd[SWITCHED-1:0] <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/fdcg_timer.sv
module fdcg_timer
    import fdcg_pkg::*;
#(
    parameter int TICKS = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic irq_en,
    output logic fire
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(TICKS - 1);

    tmr_state_e state, state_nxt;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TM_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            TM_IDLE: state_nxt = arm ? TM_RUN : TM_IDLE;
            TM_RUN:  state_nxt = arm ? TM_RUN : ((cnt == '0) ? TM_FIRE : TM_RUN);
            TM_FIRE: state_nxt = arm ? TM_RUN : TM_IDLE;
            default: state_nxt = TM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (arm) begin
            cnt <= LOAD;
        end else if (state == TM_RUN && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        fire = (state == TM_FIRE) && irq_en;
    end
endmodule

// File: rtl/fdc_bus_glue.sv
module fdc_bus_glue
    import fdcg_pkg::*;
#(
    parameter int CLK_FREQ_HZ = 250_000_000,
    parameter int TIMEOUT_MS  = 100,
    parameter int NUM_DRIVES  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    output logic                  fdc_wr,
    output logic                  fdc_rd,
    output logic                  fdc_reg,
    output logic [7:0]            fdc_wdata,
    input  logic [7:0]            fdc_rdata,
    output logic                  fdc_reset,
    output logic                  fdc_ready,
    output logic [NUM_DRIVES-1:0] drive_hd,
    input  logic                  disk_in,
    input  logic                  fdc_irq,
    input  logic                  fdc_drq,
    output logic                  irq_line2,
    output logic                  irq_line3,
    output logic                  dma_ch2,
    output logic                  dma_ch3
);
    localparam int TICKS = CLK_FREQ_HZ / 1000 * TIMEOUT_MS;

    port_kind_e kind;
    logic       live;
    logic       dd_ctrl;
    logic [1:0] mode_q;
    logic       irq_en;
    logic       arm;
    logic       tmr_fire;
    logic       fwd;

    fdcg_decode u_dec (
        .addr     (bus_addr),
        .mode_bank(mode_q[0]),
        .kind     (kind),
        .live     (live),
        .dd_ctrl  (dd_ctrl)
    );

    fdcg_regs #(.NUM_DRIVES(NUM_DRIVES)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (bus_wr && live && kind == PK_CTRL),
        .mode_we  (bus_wr && kind == PK_MODE),
        .dd_port  (dd_ctrl),
        .wdata    (bus_wdata),
        .irq_en   (irq_en),
        .mode_q   (mode_q),
        .fdc_reset(fdc_reset),
        .ready    (fdc_ready),
        .drive_hd (drive_hd),
        .arm      (arm)
    );

    fdcg_timer #(.TICKS(TICKS)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .irq_en(irq_en),
        .fire  (tmr_fire)
    );

    assign fwd       = live && (kind == PK_STAT || kind == PK_DATA);
    assign fdc_wr    = bus_wr && fwd;
    assign fdc_rd    = bus_rd && fwd;
    assign fdc_reg   = (kind == PK_DATA);
    assign fdc_wdata = bus_wdata;

    always_comb begin
        bus_rdata = OPEN_BUS;
        if (fwd) begin
            bus_rdata = fdc_rdata;
        end else if (kind == PK_CTRL && live) begin
            bus_rdata = mode_q[0] ? HD_CTRL_RD : (DD_CTRL_RD | {3'b000, disk_in, 4'b0000});
        end else if (kind == PK_MODE) begin
            bus_rdata = MODE_RD_HI | {6'b000000, mode_q};
        end
    end

    assign irq_line3 = fdc_irq && mode_q[0];
    assign irq_line2 = (fdc_irq && !mode_q[0]) || tmr_fire;
    assign dma_ch2   = fdc_drq && mode_q[0];
    assign dma_ch3   = fdc_drq && !mode_q[0];
endmodule

// File: rtl/fdcg_checker.sv
module fdcg_checker
    import fdcg_pkg::*;
#(
    parameter int NUM_DRIVES = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [15:0]           bus_addr,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [7:0]            bus_rdata,
    input logic                  fdc_wr,
    input logic                  fdc_reset,
    input logic                  fdc_ready,
    input logic [NUM_DRIVES-1:0] drive_hd,
    input logic                  fdc_irq,
    input logic                  fdc_drq,
    input logic                  irq_line3,
    input logic                  dma_ch2,
    input logic                  dma_ch3
);
    logic unmapped;
    assign unmapped = !(bus_addr inside {HD_STAT, HD_DATA, HD_CTRL, DD_STAT, DD_DATA, DD_CTRL, MODE_PORT});

    AST_FWD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) fdc_wr |-> bus_wr); // R1
    AST_UNMAPPED_FF: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd && unmapped) |-> bus_rdata == 8'hFF); // R2
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) fdc_reset |=> !fdc_reset); // R3
    AST_RST_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) fdc_reset |-> $past(bus_wr)); // R3
    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !bus_wr |=> $stable(fdc_ready)); // R4
    AST_DRIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !bus_wr |=> $stable(drive_hd)); // R7
    AST_DMA_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(dma_ch2 && dma_ch3)); // R10
    AST_DMA_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) (dma_ch2 || dma_ch3) |-> fdc_drq); // R10
    AST_IRQ3_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) irq_line3 |-> fdc_irq); // R10
endmodule

bind fdc_bus_glue fdcg_checker #(.NUM_DRIVES(NUM_DRIVES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .fdc_wr   (fdc_wr),
    .fdc_reset(fdc_reset),
    .fdc_ready(fdc_ready),
    .drive_hd (drive_hd),
    .fdc_irq  (fdc_irq),
    .fdc_drq  (fdc_drq),
    .irq_line3(irq_line3),
    .dma_ch2  (dma_ch2),
    .dma_ch3  (dma_ch3)
);

// File: tb/tb_fdc_bus_glue.sv
`timescale 1ns/1ps
module tb_fdc_bus_glue;
    localparam int NDRV  = 4;
    localparam int TICKS = 20;

    logic clk = 0;
    logic rst_n = 0;
    logic [15:0] bus_addr = '0;
    logic bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic fdc_wr, fdc_rd, fdc_reg;
    logic [7:0] fdc_wdata;
    logic [7:0] fdc_rdata = 8'h5A;
    logic fdc_reset, fdc_ready;
    logic [NDRV-1:0] drive_hd;
    logic disk_in = 0, fdc_irq = 0, fdc_drq = 0;
    logic irq_line2, irq_line3, dma_ch2, dma_ch3;

    int checks = 0;
    int errors = 0;
    logic cap_wr, cap_reg;
    logic [7:0] cap_wdata, rd_val;

    always #2 clk = ~clk;

    fdc_bus_glue #(.CLK_FREQ_HZ(20000), .TIMEOUT_MS(1), .NUM_DRIVES(NDRV)) dut (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        #1;
        cap_wr = fdc_wr; cap_reg = fdc_reg; cap_wdata = fdc_wdata;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic bus_read(input logic [15:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        #1;
        rd_val = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    // {mode[1:0], address[15:0], expected read[7:0]}
    localparam logic [25:0] VEC [16] = '{
        {2'd3, 16'h0090, 8'h5A},  // R1 live status
        {2'd3, 16'h0092, 8'h5A},  // R1 live data
        {2'd3, 16'h0094, 8'h44},  // R9
        {2'd3, 16'h00BE, 8'hFB},  // R8
        {2'd3, 16'h00C8, 8'hFF},  // R2 dead bank
        {2'd3, 16'h00CC, 8'hFF},  // R2 dead control
        {2'd3, 16'h0190, 8'hFF},  // R2 undecoded
        {2'd0, 16'h00C8, 8'h5A},  // R1
        {2'd0, 16'h00CA, 8'h5A},  // R1
        {2'd0, 16'h00CC, 8'h64},  // R9 no disk
        {2'd0, 16'h0090, 8'hFF},  // R2
        {2'd0, 16'h0094, 8'hFF},  // R2
        {2'd0, 16'h00BE, 8'hF8},  // R8
        {2'd2, 16'h00BE, 8'hFA},  // R8
        {2'd1, 16'h00BE, 8'hF9},  // R8
        {2'd1, 16'h0000, 8'hFF}   // R2
    };

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic seen;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11 drive_hd", 16'(drive_hd), 16'hF);
        chk("R11 ready", 16'(fdc_ready), 0);
        chk("R11 reset pulse", 16'(fdc_reset), 0);
        chk("R11 irq2", 16'(irq_line2), 0);
        bus_read(16'h00BE);
        chk("R11 mode read", 16'(rd_val), 16'hFB);

        for (int i = 0; i < 16; i++) begin
            bus_write(16'h00BE, {6'b0, VEC[i][25:24]});
            bus_read(VEC[i][23:8]);
            chk($sformatf("R1/R2/R8/R9 table[%0d]", i), 16'(rd_val), 16'(VEC[i][7:0]));
        end

        // R9 disk present
        bus_write(16'h00BE, 8'h00);
        disk_in = 1;
        bus_read(16'h00CC);
        chk("R9 disk bit", 16'(rd_val), 16'h74);
        disk_in = 0;

        // R10 routing
        fdc_irq = 1; fdc_drq = 1; #1;
        chk("R10 mode0 route", 16'({irq_line3, irq_line2, dma_ch2, dma_ch3}), 16'b0101);
        bus_write(16'h00BE, 8'h03);
        #1;
        chk("R10 mode1 route", 16'({irq_line3, irq_line2, dma_ch2, dma_ch3}), 16'b1010);
        fdc_irq = 0; fdc_drq = 0;

        // R1 write forwarding
        bus_write(16'h0092, 8'hA7);
        chk("R1 live data write", 16'({cap_wr, cap_reg, cap_wdata}), 16'h3A7);
        bus_write(16'h0090, 8'h11);
        chk("R1 live status write", 16'({cap_wr, cap_reg}), 16'b10);
        bus_write(16'h00CA, 8'h11);
        chk("R1 dead bank write", 16'(cap_wr), 0);

        // R3 reset pulse
        bus_write(16'h0094, 8'h80);
        chk("R3 no pulse when bit7 already set", 16'(fdc_reset), 0);
        bus_write(16'h0094, 8'h00);
        chk("R3 no pulse on clear", 16'(fdc_reset), 0);
        bus_write(16'h0094, 8'h80);
        chk("R3 pulse on rise", 16'(fdc_reset), 1);
        @(negedge clk);
        chk("R3 pulse one cycle", 16'(fdc_reset), 0);
        bus_write(16'h00CC, 8'h00);  // dead bank, must not clear stored bit 7
        bus_write(16'h0094, 8'h80);
        chk("R1 dead control write ignored", 16'(fdc_reset), 0);

        // R4 ready
        bus_write(16'h0094, 8'h40);
        chk("R4 ready set", 16'(fdc_ready), 1);
        bus_write(16'h00BE, 8'h00);
        bus_write(16'h00CC, 8'h00);
        chk("R4 CC bit5 clear holds", 16'(fdc_ready), 1);
        bus_write(16'h00CC, 8'h20);
        chk("R4 CC bit5 set clears", 16'(fdc_ready), 0);
        bus_write(16'h00CC, 8'h60);
        chk("R4 CC bit5 set sets", 16'(fdc_ready), 1);

        // R7 drive type (mode now 0)
        chk("R7 dd after fall", 16'(drive_hd), 16'hC);
        bus_write(16'h00BE, 8'h01);
        chk("R7 no change bit1 low", 16'(drive_hd), 16'hC);
        bus_write(16'h00BE, 8'h03);
        chk("R7 hd after rise", 16'(drive_hd), 16'hF);

        // R5 timer expiry
        bus_write(16'h0094, 8'h05);
        repeat (TICKS - 1) @(negedge clk);
        chk("R5 before expiry", 16'(irq_line2), 0);
        @(negedge clk);
        chk("R5 expiry pulse", 16'(irq_line2), 1);
        @(negedge clk);
        chk("R5 pulse one cycle", 16'(irq_line2), 0);

        // R5 restart discards pending expiry
        bus_write(16'h0094, 8'h05);
        repeat (9) @(negedge clk);
        bus_write(16'h0094, 8'h05);
        repeat (9) @(negedge clk);
        chk("R5 old expiry cancelled", 16'(irq_line2), 0);
        repeat (10) @(negedge clk);
        chk("R5 before new expiry", 16'(irq_line2), 0);
        @(negedge clk);
        chk("R5 new expiry", 16'(irq_line2), 1);

        // R6 no pulse with bit2 clear
        bus_write(16'h0094, 8'h01);
        seen = 0;
        repeat (TICKS + 5) begin
            @(negedge clk);
            seen |= irq_line2;
        end
        chk("R6 masked expiry", 16'(seen), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule